// File: doc/BRIEF.md
# Packet Radio Receive Filter

This block is the receive side of a packet radio link, placed between the demodulator and the UART that carries data to the host. The demodulator raises a one-cycle sync strobe when it has seen the preamble and a valid start code. It then hands over one byte per valid strobe. The block captures a three-byte header and collects the payload. It checks a 16-bit CRC and applies the acceptance rules: the group must match, and the sender's role must suit the local role unless the local node runs peer-to-peer.

Payload bytes are held in a local buffer until every check has passed. A rejected packet therefore leaves no trace on the output. Accepted payload is presented one byte at a time on a valid/ready output toward the UART transmitter. If the gap between bytes reaches a programmable cycle count, the packet is abandoned and the block goes back to listening.

Top module: `pkt_rx_filter`

## Requirements
- R1: After reset the block is listening and `out_valid` is low.
- R2: Bytes that arrive while listening, without a preceding `in_sync` strobe, are ignored and produce no output.
- R3: A frame after `in_sync` is: group byte, flag byte (bit 0 = 1 when the sender is a master), length byte, `length` payload bytes, then CRC high byte and CRC low byte. The payload of an accepted frame is output in arrival order.
- R4: The CRC is CRC-16 with polynomial 0x1021 and initial value 0xFFFF, processed MSB first, with no reflection and no final XOR. It covers the header and the payload. On a mismatch the frame is discarded.
- R5: A frame whose group byte differs from `cfg_group` is discarded.
- R6: When `cfg_peer` is 0, the role rule applies. A master (`cfg_master`=1) accepts only frames with flag bit 0 = 0. A slave (`cfg_master`=0) accepts only frames with flag bit 0 = 1.
- R7: When `cfg_peer` is 1, the role rule always passes.
- R8: A length of 0 or above MTU rejects the frame at its header. A length equal to MTU is accepted.
- R9: In the header, payload and CRC phases, TO_CYC consecutive cycles without a byte abandon the frame. Shorter gaps do not.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid` and `out_byte` hold their values.
- R11: While accepted payload is being delivered, `in_sync` and input bytes are ignored.
- R12: No byte of a rejected frame ever appears on the output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_sync | input | 1 | Preamble and start code seen (one-cycle strobe) |
| in_valid | input | 1 | `in_byte` holds a received byte |
| in_byte | input | 8 | Demodulated byte |
| cfg_group | input | 8 | Local group identifier |
| cfg_master | input | 1 | Local role: 1 master, 0 slave |
| cfg_peer | input | 1 | Peer-to-peer mode, bypasses the role rule |
| out_valid | output | 1 | Payload byte available |
| out_ready | input | 1 | UART transmitter takes the byte |
| out_byte | output | 8 | Payload byte |

## Verification
The receive path is driven with several kinds of frame:
- A clean frame in each role combination, which separates the role rule from the group check.
- Frames that differ from a good one in exactly one field (CRC, group, length), so each rejection path is exercised on its own.
- A length at MTU and a length one above it, which locate the boundary of the length limit.
- Inter-byte gaps well below and well above the timeout, which tell a tolerated pause from an abandoned frame.
- A stalled output with a second frame arriving during delivery, which shows both the output hold and the deafness while sending.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_HDR  = 3'd1,
    ST_DATA = 3'd2,
    ST_CRC  = 3'd3,
    ST_SEND = 3'd4
  } rx_state_e;

  localparam logic [15:0] CRC_POLY = 16'h1021;
  localparam logic [15:0] CRC_SEED = 16'hFFFF;

  function automatic logic [15:0] crc16_byte(input logic [15:0] crc, input logic [7:0] data);
    logic [15:0] c;
    c = crc ^ {data, 8'h00};
    for (int b = 0; b < 8; b++) begin
      c = c[15] ? ((c << 1) ^ CRC_POLY) : (c << 1);
    end
    return c;
  endfunction

endpackage

// File: rtl/pkt_rx_crc16.sv
module pkt_rx_crc16
  import pkt_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic [7:0]  din,
  output logic [15:0] crc
);

  logic [15:0] crc_d;

  always_comb begin
    crc_d = crc;
    if (clr)     crc_d = CRC_SEED;
    else if (en) crc_d = crc16_byte(crc, din);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc <= CRC_SEED;
    else        crc <= crc_d;
  end

endmodule

// File: rtl/pkt_rx_accept.sv
module pkt_rx_accept #(
  parameter int MTU = 32
) (
  input  logic [7:0] hdr_group,
  input  logic       hdr_from_master,
  input  logic [7:0] hdr_len,
  input  logic [7:0] cfg_group,
  input  logic       cfg_master,
  input  logic       cfg_peer,
  output logic       hdr_ok
);

  localparam logic [7:0] MTU_B = 8'(MTU);

  logic group_ok;
  logic role_ok;
  logic len_ok;

  always_comb begin
    group_ok = (hdr_group == cfg_group);
    role_ok  = cfg_peer | (hdr_from_master != cfg_master);
    len_ok   = (hdr_len != 8'd0) && (hdr_len <= MTU_B);
    hdr_ok   = group_ok & role_ok & len_ok;
  end

endmodule

// File: rtl/pkt_rx_pbuf.sv
module pkt_rx_pbuf #(
  parameter int MTU   = 32,
  parameter int IDX_W = $clog2(MTU)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [7:0]       wr_data,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [7:0]       rd_data
);

  logic [7:0] mem_q [MTU];

  always_ff @(posedge clk) begin
    if (wr_en) mem_q[wr_idx] <= wr_data;
  end

  assign rd_data = mem_q[rd_idx];

  AST_WR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (int'(wr_idx) < MTU)); // R8

endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int MTU    = 32,
  parameter int TO_CYC = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       in_sync,
  input  logic       in_valid,
  input  logic [7:0] in_byte,
  input  logic [7:0] cfg_group,
  input  logic       cfg_master,
  input  logic       cfg_peer,
  output logic       out_valid,
  input  logic       out_ready,
  output logic [7:0] out_byte
);

  localparam int IDX_W = $clog2(MTU);
  localparam int TMO_W = $clog2(TO_CYC + 1);
  localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TO_CYC - 1);
  localparam logic [7:0] MTU_B = 8'(MTU);

  rx_state_e        state_q, state_d;
  logic [1:0]       hdr_idx_q, hdr_idx_d;
  logic [7:0]       grp_q, grp_d;
  logic             from_m_q, from_m_d;
  logic [7:0]       len_q, len_d;
  logic [IDX_W-1:0] dat_idx_q, dat_idx_d;
  logic [IDX_W-1:0] rd_idx_q, rd_idx_d;
  logic             crc_idx_q, crc_idx_d;
  logic             hi_ok_q, hi_ok_d;
  logic [TMO_W-1:0] tmo_q, tmo_d;

  logic        hdr_ok;
  logic        crc_clr, crc_en;
  logic [15:0] crc_w;
  logic        buf_we;
  logic [7:0]  buf_rd;
  logic        rx_busy;
  logic        send_last;

  pkt_rx_crc16 u_crc (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (crc_clr),
    .en    (crc_en),
    .din   (in_byte),
    .crc   (crc_w)
  );

  pkt_rx_accept #(.MTU(MTU)) u_accept (
    .hdr_group       (grp_q),
    .hdr_from_master (from_m_q),
    .hdr_len         (in_byte),
    .cfg_group       (cfg_group),
    .cfg_master      (cfg_master),
    .cfg_peer        (cfg_peer),
    .hdr_ok          (hdr_ok)
  );

  pkt_rx_pbuf #(.MTU(MTU), .IDX_W(IDX_W)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (buf_we),
    .wr_idx  (dat_idx_q),
    .wr_data (in_byte),
    .rd_idx  (rd_idx_q),
    .rd_data (buf_rd)
  );

  assign rx_busy   = (state_q == ST_HDR) || (state_q == ST_DATA) || (state_q == ST_CRC);
  assign send_last = (8'(rd_idx_q) + 8'd1 == len_q);
  assign out_valid = (state_q == ST_SEND);
  assign out_byte  = buf_rd;

  // next-state logic
  always_comb begin
    state_d   = state_q;
    hdr_idx_d = hdr_idx_q;
    grp_d     = grp_q;
    from_m_d  = from_m_q;
    len_d     = len_q;
    dat_idx_d = dat_idx_q;
    rd_idx_d  = rd_idx_q;
    crc_idx_d = crc_idx_q;
    hi_ok_d   = hi_ok_q;
    tmo_d     = tmo_q;
    crc_clr   = 1'b0;
    crc_en    = 1'b0;
    buf_we    = 1'b0;

    case (state_q)
      ST_IDLE: begin
        if (in_sync) begin
          state_d   = ST_HDR;
          hdr_idx_d = 2'd0;
          tmo_d     = '0;
          crc_clr   = 1'b1;
        end
      end
      ST_HDR: begin
        if (in_valid) begin
          crc_en    = 1'b1;
          hdr_idx_d = hdr_idx_q + 2'd1;
          case (hdr_idx_q)
            2'd0:    grp_d    = in_byte;
            2'd1:    from_m_d = in_byte[0];
            default: begin
              len_d     = in_byte;
              dat_idx_d = '0;
              state_d   = hdr_ok ? ST_DATA : ST_IDLE;
            end
          endcase
        end
      end
      ST_DATA: begin
        if (in_valid) begin
          crc_en    = 1'b1;
          buf_we    = 1'b1;
          dat_idx_d = dat_idx_q + IDX_W'(1);
          if (8'(dat_idx_q) + 8'd1 == len_q) begin
            state_d   = ST_CRC;
            crc_idx_d = 1'b0;
          end
        end
      end
      ST_CRC: begin
        if (in_valid) begin
          crc_idx_d = 1'b1;
          rd_idx_d  = '0;
          if (!crc_idx_q) hi_ok_d = (in_byte == crc_w[15:8]);
          else state_d = (hi_ok_q && (in_byte == crc_w[7:0])) ? ST_SEND : ST_IDLE;
        end
      end
      ST_SEND: begin
        if (out_ready) begin
          if (send_last) state_d  = ST_IDLE;
          else           rd_idx_d = rd_idx_q + IDX_W'(1);
        end
      end
      default: state_d = ST_IDLE;
    endcase

    // inter-byte watchdog for the receive phases
    if (rx_busy) begin
      if (in_valid)               tmo_d = '0;
      else if (tmo_q == TMO_LAST) state_d = ST_IDLE;
      else                        tmo_d = tmo_q + TMO_W'(1);
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      hdr_idx_q <= '0;
      grp_q     <= '0;
      from_m_q  <= 1'b0;
      len_q     <= '0;
      dat_idx_q <= '0;
      rd_idx_q  <= '0;
      crc_idx_q <= 1'b0;
      hi_ok_q   <= 1'b0;
      tmo_q     <= '0;
    end else begin
      state_q   <= state_d;
      hdr_idx_q <= hdr_idx_d;
      grp_q     <= grp_d;
      from_m_q  <= from_m_d;
      len_q     <= len_d;
      dat_idx_q <= dat_idx_d;
      rd_idx_q  <= rd_idx_d;
      crc_idx_q <= crc_idx_d;
      hi_ok_q   <= hi_ok_d;
      tmo_q     <= tmo_d;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_byte))); // R10

  AST_CRC_BAD_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CRC && in_valid && crc_idx_q && !(hi_ok_q && in_byte == crc_w[7:0]))
      |=> (state_q == ST_IDLE)); // R4

  AST_TIMEOUT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_busy && !in_valid && tmo_q == TMO_LAST) |=> (state_q == ST_IDLE)); // R9

  AST_PEER_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_HDR && in_valid && hdr_idx_q == 2'd2 && cfg_peer && grp_q == cfg_group
      && in_byte != 8'd0 && in_byte <= MTU_B) |=> (state_q == ST_DATA)); // R7

  AST_SEND_DEAF: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !(out_ready && send_last)) |=> out_valid); // R11

  AST_LEN_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_DATA) |-> (len_q != 8'd0 && len_q <= MTU_B)); // R8

endmodule

// File: tb/pkt_rx_filter_tb_top.sv
module pkt_rx_filter_tb_top;

  localparam int MTU = 8;
  localparam int TO  = 16;

  logic       clk;
  logic       rst_n;
  logic       in_sync, in_valid;
  logic [7:0] in_byte;
  logic [7:0] cfg_group;
  logic       cfg_master, cfg_peer;
  logic       out_valid, out_ready;
  logic [7:0] out_byte;

  int n_chk, n_bad;
  bit done;

  logic [7:0] frame [64];
  int         frame_n;
  logic [7:0] exp_pay [64];
  int         exp_n;
  logic [7:0] got [256];
  int         got_n;

  pkt_rx_filter #(.MTU(MTU), .TO_CYC(TO)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_sync(in_sync), .in_valid(in_valid), .in_byte(in_byte),
    .cfg_group(cfg_group), .cfg_master(cfg_master), .cfg_peer(cfg_peer),
    .out_valid(out_valid), .out_ready(out_ready), .out_byte(out_byte)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready && got_n < 256) begin
      got[got_n] = out_byte;
      got_n++;
    end
  end

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] crc_ref(input int n);
    logic [15:0] r;
    r = 16'hFFFF;
    for (int i = 0; i < n; i++) begin
      for (int b = 7; b >= 0; b--) begin
        logic fb;
        fb = r[15] ^ frame[i][b];
        r  = {r[14:0], 1'b0};
        if (fb) r = r ^ 16'h1021;
      end
    end
    return r;
  endfunction

  // build a frame; corrupt=1 flips the low CRC byte
  task automatic build(input logic [7:0] g, input logic [7:0] f, input int len,
                       input int seed, input bit corrupt);
    logic [15:0] c;
    frame[0] = g;
    frame[1] = f;
    frame[2] = 8'(len);
    for (int i = 0; i < len; i++) begin
      frame[3+i]  = 8'(seed + i * 37);
      exp_pay[i]  = frame[3+i];
    end
    exp_n = len;
    c = crc_ref(3 + len);
    frame[3+len] = c[15:8];
    frame[4+len] = corrupt ? (c[7:0] ^ 8'h01) : c[7:0];
    frame_n = 5 + len;
  endtask

  task automatic send(input bit with_sync, input int gap);
    if (with_sync) begin
      in_sync = 1'b1;
      tick();
      in_sync = 1'b0;
    end
    for (int i = 0; i < frame_n; i++) begin
      in_valid = 1'b1;
      in_byte  = frame[i];
      tick();
      in_valid = 1'b0;
      repeat (gap) tick();
    end
  endtask

  task automatic expect_out(string req, bit accepted);
    repeat (40) tick();
    check(req, got_n, accepted ? exp_n : 0);
    if (accepted && got_n == exp_n)
      for (int i = 0; i < exp_n; i++) check(req, int'(got[i]), int'(exp_pay[i]));
    got_n = 0;
  endtask

  task automatic set_cfg(logic [7:0] g, logic m, logic p);
    cfg_group = g; cfg_master = m; cfg_peer = p;
  endtask

  task automatic t_reset();
    check("R1 out_valid after reset", int'(out_valid), 0);
  endtask

  task automatic t_basic();
    set_cfg(8'h5A, 1'b0, 1'b0);
    build(8'h5A, 8'h01, 5, 3, 1'b0); send(1'b1, 0); expect_out("R3 R4 slave gets master frame", 1'b1);
    build(8'h5A, 8'h81, 3, 90, 1'b0); send(1'b1, 2); expect_out("R3 paced frame, flag bit 0 only", 1'b1);
  endtask

  task automatic t_crc();
    set_cfg(8'h5A, 1'b0, 1'b0);
    build(8'h5A, 8'h01, 4, 11, 1'b1); send(1'b1, 0); expect_out("R4 R12 bad CRC dropped", 1'b0);
  endtask

  task automatic t_group();
    set_cfg(8'h5A, 1'b0, 1'b0);
    build(8'h5B, 8'h01, 4, 12, 1'b0); send(1'b1, 0); expect_out("R5 group mismatch dropped", 1'b0);
  endtask

  task automatic t_role();
    set_cfg(8'h21, 1'b0, 1'b0);
    build(8'h21, 8'h00, 4, 13, 1'b0); send(1'b1, 0); expect_out("R6 slave rejects slave", 1'b0);
    set_cfg(8'h21, 1'b1, 1'b0);
    build(8'h21, 8'h00, 4, 14, 1'b0); send(1'b1, 0); expect_out("R6 master accepts slave", 1'b1);
    build(8'h21, 8'h01, 4, 15, 1'b0); send(1'b1, 0); expect_out("R6 master rejects master", 1'b0);
  endtask

  task automatic t_peer();
    set_cfg(8'h33, 1'b0, 1'b1);
    build(8'h33, 8'h00, 2, 16, 1'b0); send(1'b1, 0); expect_out("R7 peer accepts slave", 1'b1);
    set_cfg(8'h33, 1'b1, 1'b1);
    build(8'h33, 8'h01, 2, 17, 1'b0); send(1'b1, 0); expect_out("R7 peer accepts master", 1'b1);
  endtask

  task automatic t_len();
    set_cfg(8'h44, 1'b1, 1'b0);
    build(8'h44, 8'h00, MTU, 18, 1'b0); send(1'b1, 0); expect_out("R8 length at MTU", 1'b1);
    build(8'h44, 8'h00, MTU + 1, 19, 1'b0); send(1'b1, 0); expect_out("R8 length above MTU", 1'b0);
    build(8'h44, 8'h00, 0, 20, 1'b0); send(1'b1, 0); expect_out("R8 zero length", 1'b0);
  endtask

  task automatic t_nosync();
    set_cfg(8'h44, 1'b1, 1'b0);
    build(8'h44, 8'h00, 3, 21, 1'b0); send(1'b0, 0); expect_out("R2 no sync ignored", 1'b0);
  endtask

  task automatic t_timeout();
    set_cfg(8'h44, 1'b1, 1'b0);
    build(8'h44, 8'h00, 3, 22, 1'b0); send(1'b1, 5); expect_out("R9 short gaps tolerated", 1'b1);
    build(8'h44, 8'h00, 3, 23, 1'b0); send(1'b1, 3 * TO); expect_out("R9 long gap abandons", 1'b0);
  endtask

  task automatic t_stall();
    set_cfg(8'h44, 1'b1, 1'b0);
    out_ready = 1'b0;
    build(8'h44, 8'h00, 4, 24, 1'b0); send(1'b1, 0);
    repeat (3) tick();
    check("R10 valid while stalled", int'(out_valid), 1);
    check("R10 first byte presented", int'(out_byte), int'(exp_pay[0]));
    build(8'h44, 8'h00, 5, 99, 1'b0); send(1'b1, 0);
    repeat (10) tick();
    check("R10 valid still held", int'(out_valid), 1);
    check("R11 byte unchanged by new frame", int'(out_byte), 8'(24));
    build(8'h44, 8'h00, 4, 24, 1'b0);
    out_ready = 1'b1;
    expect_out("R11 only first frame delivered", 1'b1);
  endtask

  initial begin
    n_chk = 0; n_bad = 0; done = 1'b0; got_n = 0;
    rst_n = 1'b0; in_sync = 1'b0; in_valid = 1'b0; in_byte = 8'h00;
    out_ready = 1'b1;
    set_cfg(8'h00, 1'b0, 1'b0);
    repeat (4) tick();
    t_reset();
    rst_n = 1'b1;
    repeat (2) tick();
    t_reset();
    t_basic();
    t_crc();
    t_group();
    t_role();
    t_peer();
    t_len();
    t_nosync();
    t_timeout();
    t_stall();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

endmodule